// File: doc/BRIEF.md
# Threshold Offset Byte Registers

This block holds the four byte-wide offsets that a FIFO's flag logic uses as its almost-empty and almost-full thresholds. Software or a controlling block loads them one byte at a time through a single load path. The same path lets the bytes be read back one at a time. A two-bit selector, written as a small state machine, picks the byte that the next access uses. After each write or readback it steps through a fixed cyclic order: empty threshold low byte, empty threshold high byte, full threshold low byte, full threshold high byte, and then back to the first.

A load does not have to cover all four bytes. Raising the load control stops the sequence, and the selector keeps its position, so the next load continues with the following byte. The block joins the byte pairs into two 16-bit thresholds and drives them continuously to the flag comparators, which sit outside this block. Both the load side and the readback side work on a single clock.

The selector states are `SEL_EMPTY_LO`, `SEL_EMPTY_HI`, `SEL_FULL_LO` and `SEL_FULL_HI`. There is one transition, "step", from each state to the next in that list, with `SEL_FULL_HI` stepping back to `SEL_EMPTY_LO`. A step happens on every accepted write or readback. Reset forces the selector to `SEL_EMPTY_LO`.

Top module: `thresh_offset_regs`

## Requirements
- R1: While `rst_n` is low, the four bytes return to their defaults: 0x07 for each low byte and 0x00 for each high byte. Both thresholds then read 0x0007, `rb_data` is 0, `rb_valid` is 0, and the selector is at the empty low byte.
- R2: When `load_n`=0 and `wr_en_n`=0 on a rising clock, `din[7:0]` is stored in the selected byte and the selector steps. The order is empty-low, empty-high, full-low, full-high. `ae_thresh` = {empty-high, empty-low} and `af_thresh` = {full-high, full-low}.
- R3: After the full-high byte, the next write or readback goes to the empty-low byte.
- R4: With `load_n`=1, no byte changes and the selector holds. A later load continues with the byte that follows the last one accessed.
- R5: With `load_n`=0 and `wr_en_n`=1, no byte is written.
- R6: A readback happens when `load_n`=0, `rd_en_a_n`=0, `rd_en_b_n`=0 and no write is accepted in that cycle. After the rising edge, `rb_data` shows the selected byte and `rb_valid` is 1 for that one cycle. The selector then steps.
- R7: If either read enable is high, or no readback occurs for any other reason, `rb_valid` is 0 and `rb_data` holds its last value.
- R8: When a write and a readback are requested in the same cycle, only the write takes effect.
- R9: `din[8]` is ignored on load, and `rb_data[8]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for load and readback |
| rst_n | input | 1 | Active-low reset |
| load_n | input | 1 | Active-low offset access select |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| din | input | 9 | Load data; bit 8 unused |
| rb_data | output | 9 | Readback register; bit 8 always 0 |
| rb_valid | output | 1 | One-cycle pulse after a readback |
| ae_thresh | output | 16 | Assembled almost-empty threshold |
| af_thresh | output | 16 | Assembled almost-full threshold |

## Verification
Checker properties run on every cycle and cover the following:
- the top readback bit is always zero;
- every readback request produces a valid pulse, and every pulse traces back to a request;
- both thresholds stay unchanged in cycles with no write;
- the readback register holds when nothing reads.

Only the bench scenarios can show which byte a given access reaches. Those scenarios cover the order of writes, the wrap from the last byte, continuation after a partial load, write priority over a simultaneous read, and the selector's return to the first byte on reset.

// File: rtl/thr_ofs_pkg.sv
package thr_ofs_pkg;

    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } ofs_sel_e;

    localparam int unsigned NUM_OFS = 4;

endpackage

// File: rtl/ofs_ptr_fsm.sv
module ofs_ptr_fsm
    import thr_ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_e sel
);

    ofs_sel_e state_q;
    ofs_sel_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_EMPTY_LO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SEL_EMPTY_LO: state_d = SEL_EMPTY_HI;
                SEL_EMPTY_HI: state_d = SEL_FULL_LO;
                SEL_FULL_LO:  state_d = SEL_FULL_HI;
                SEL_FULL_HI:  state_d = SEL_EMPTY_LO;
                default:      state_d = SEL_EMPTY_LO;
            endcase
        end
    end

    assign sel = state_q;

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import thr_ofs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter logic [BYTE_W-1:0] DEF_LO = 8'h07,
    parameter logic [BYTE_W-1:0] DEF_HI = 8'h00,
    localparam int unsigned FLAT_W = NUM_OFS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  ofs_sel_e          sel,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [FLAT_W-1:0] bytes_flat
);

    for (genvar i = 0; i < NUM_OFS; i++) begin : g_byte
        localparam logic [BYTE_W-1:0] DEF_VAL = (i % 2 == 0) ? DEF_LO : DEF_HI;
        logic [BYTE_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= DEF_VAL;
            end else if (wr_stb && (sel == ofs_sel_e'(i))) begin
                val_q <= wr_byte;
            end
        end

        assign bytes_flat[i*BYTE_W +: BYTE_W] = val_q;
    end

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import thr_ofs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned FLAT_W = NUM_OFS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  ofs_sel_e          sel,
    input  logic [FLAT_W-1:0] bytes_flat,
    output logic              rb_valid,
    output logic [BYTE_W:0]   rb_data
);

    logic [BYTE_W-1:0] picked;

    always_comb begin
        unique case (sel)
            SEL_EMPTY_LO: picked = bytes_flat[0*BYTE_W +: BYTE_W];
            SEL_EMPTY_HI: picked = bytes_flat[1*BYTE_W +: BYTE_W];
            SEL_FULL_LO:  picked = bytes_flat[2*BYTE_W +: BYTE_W];
            SEL_FULL_HI:  picked = bytes_flat[3*BYTE_W +: BYTE_W];
            default:      picked = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_valid <= 1'b0;
            rb_data  <= '0;
        end else begin
            rb_valid <= rd_stb;
            if (rd_stb) begin
                rb_data <= {1'b0, picked};
            end
        end
    end

endmodule

// File: rtl/thresh_offset_regs.sv
module thresh_offset_regs
    import thr_ofs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter logic [BYTE_W-1:0] DEF_LO = 8'h07,
    parameter logic [BYTE_W-1:0] DEF_HI = 8'h00,
    localparam int unsigned THR_W = 2 * BYTE_W,
    localparam int unsigned FLAT_W = NUM_OFS * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic             rd_en_a_n,
    input  logic             rd_en_b_n,
    input  logic [BYTE_W:0]  din,
    output logic [BYTE_W:0]  rb_data,
    output logic             rb_valid,
    output logic [THR_W-1:0] ae_thresh,
    output logic [THR_W-1:0] af_thresh
);

    logic              wr_stb;
    logic              rd_stb;
    ofs_sel_e          sel;
    logic [FLAT_W-1:0] bytes_flat;

    assign wr_stb = !load_n && !wr_en_n;
    assign rd_stb = !load_n && !rd_en_a_n && !rd_en_b_n && !wr_stb;

    ofs_ptr_fsm u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (wr_stb || rd_stb),
        .sel   (sel)
    );

    ofs_bank #(
        .BYTE_W (BYTE_W),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .sel        (sel),
        .wr_byte    (din[BYTE_W-1:0]),
        .bytes_flat (bytes_flat)
    );

    ofs_readback #(
        .BYTE_W (BYTE_W)
    ) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .sel        (sel),
        .bytes_flat (bytes_flat),
        .rb_valid   (rb_valid),
        .rb_data    (rb_data)
    );

    assign ae_thresh = bytes_flat[0 +: THR_W];
    assign af_thresh = bytes_flat[THR_W +: THR_W];

endmodule

// File: rtl/thresh_offset_regs_chk.sv
module thresh_offset_regs_chk #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned THR_W = 2 * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             wr_en_n,
    input logic             rd_en_a_n,
    input logic             rd_en_b_n,
    input logic [BYTE_W:0]  rb_data,
    input logic             rb_valid,
    input logic [THR_W-1:0] ae_thresh,
    input logic [THR_W-1:0] af_thresh
);

    logic read_req;
    assign read_req = !load_n && !rd_en_a_n && !rd_en_b_n && wr_en_n;

    // R9
    rb_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_data[BYTE_W] == 1'b0);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |=> rb_valid);

    // R8
    rb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> $past(read_req));

    // R4
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || wr_en_n) |=> ($stable(ae_thresh) && $stable(af_thresh)));

    // R7
    rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !read_req |=> $stable(rb_data));

endmodule

bind thresh_offset_regs thresh_offset_regs_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .wr_en_n   (wr_en_n),
    .rd_en_a_n (rd_en_a_n),
    .rd_en_b_n (rd_en_b_n),
    .rb_data   (rb_data),
    .rb_valid  (rb_valid),
    .ae_thresh (ae_thresh),
    .af_thresh (af_thresh)
);

// File: tb/thresh_offset_regs_bench.sv
module thresh_offset_regs_bench;

    typedef struct packed {
        logic        ld_n;
        logic        wr_n;
        logic        ra_n;
        logic        rb_n;
        logic [8:0]  din;
        logic [15:0] ae;
        logic [15:0] af;
        logic        rbv;
        logic [8:0]  rbd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1, 9'h000, 16'h0007, 16'h0007, 1'b0, 9'h000, 8'd1}, // R1 idle
        '{1'b0,1'b0,1'b1,1'b1, 9'h1A5, 16'h00A5, 16'h0007, 1'b0, 9'h000, 8'd9}, // R9 R2 empty lo
        '{1'b1,1'b0,1'b1,1'b1, 9'h033, 16'h00A5, 16'h0007, 1'b0, 9'h000, 8'd4}, // R4 load off
        '{1'b0,1'b1,1'b1,1'b1, 9'h044, 16'h00A5, 16'h0007, 1'b0, 9'h000, 8'd5}, // R5 no enable
        '{1'b0,1'b0,1'b1,1'b1, 9'h012, 16'h12A5, 16'h0007, 1'b0, 9'h000, 8'd4}, // R4 continues empty hi
        '{1'b0,1'b0,1'b1,1'b1, 9'h03C, 16'h12A5, 16'h003C, 1'b0, 9'h000, 8'd2}, // R2 full lo
        '{1'b0,1'b0,1'b1,1'b1, 9'h001, 16'h12A5, 16'h013C, 1'b0, 9'h000, 8'd2}, // R2 full hi
        '{1'b0,1'b0,1'b1,1'b1, 9'h05A, 16'h125A, 16'h013C, 1'b0, 9'h000, 8'd3}, // R3 wrap
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h125A, 16'h013C, 1'b1, 9'h012, 8'd6}, // R6 read empty hi
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h125A, 16'h013C, 1'b1, 9'h03C, 8'd6}, // R6 read full lo
        '{1'b0,1'b1,1'b0,1'b1, 9'h000, 16'h125A, 16'h013C, 1'b0, 9'h03C, 8'd7}, // R7 one enable
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h125A, 16'h013C, 1'b1, 9'h001, 8'd6}, // R6 read full hi
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h125A, 16'h013C, 1'b1, 9'h05A, 8'd3}, // R3 read wraps
        '{1'b0,1'b0,1'b0,1'b0, 9'h077, 16'h775A, 16'h013C, 1'b0, 9'h05A, 8'd8}, // R8 write wins
        '{1'b1,1'b1,1'b0,1'b0, 9'h000, 16'h775A, 16'h013C, 1'b0, 9'h05A, 8'd7}, // R7 load off
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h775A, 16'h013C, 1'b1, 9'h03C, 8'd8}  // R8 ptr stepped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        rd_en_a_n = 1'b1;
    logic        rd_en_b_n = 1'b1;
    logic [8:0]  din = '0;
    logic [8:0]  rb_data;
    logic        rb_valid;
    logic [15:0] ae_thresh;
    logic [15:0] af_thresh;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    thresh_offset_regs u_thresh_offset_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wr_en_n   (wr_en_n),
        .rd_en_a_n (rd_en_a_n),
        .rd_en_b_n (rd_en_b_n),
        .din       (din),
        .rb_data   (rb_data),
        .rb_valid  (rb_valid),
        .ae_thresh (ae_thresh),
        .af_thresh (af_thresh)
    );

    task automatic check_all(input string tag, input logic [15:0] ae, input logic [15:0] af,
                             input logic rbv, input logic [8:0] rbd);
        checks++;
        if (ae_thresh !== ae || af_thresh !== af || rb_valid !== rbv || rb_data !== rbd) begin
            errors++;
            $display("FAIL %s: got ae=%h af=%h v=%b rb=%h, expected ae=%h af=%h v=%b rb=%h",
                     tag, ae_thresh, af_thresh, rb_valid, rb_data, ae, af, rbv, rbd);
        end
    endtask

    task automatic step(input logic l, input logic w, input logic a, input logic b,
                        input logic [8:0] d);
        load_n = l; wr_en_n = w; rd_en_a_n = a; rd_en_b_n = b; din = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset", 16'h0007, 16'h0007, 1'b0, 9'h000);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ld_n, VECS[i].wr_n, VECS[i].ra_n, VECS[i].rb_n, VECS[i].din);
            check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                      VECS[i].ae, VECS[i].af, VECS[i].rbv, VECS[i].rbd);
        end

        // R1: mid-run reset restores defaults and selector start
        load_n = 1'b1; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 rerst", 16'h0007, 16'h0007, 1'b0, 9'h000);
        step(1'b0, 1'b0, 1'b1, 1'b1, 9'h099);
        check_all("R1 selector", 16'h0099, 16'h0007, 1'b0, 9'h000);

        // R3: readback walks all four and wraps (selector now at empty hi)
        step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        check_all("R3 rd eh", 16'h0099, 16'h0007, 1'b1, 9'h000);
        step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        check_all("R3 rd fl", 16'h0099, 16'h0007, 1'b1, 9'h007);
        step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        check_all("R3 rd fh", 16'h0099, 16'h0007, 1'b1, 9'h000);
        step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        check_all("R3 rd el", 16'h0099, 16'h0007, 1'b1, 9'h099);
        step(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        check_all("R7 idle", 16'h0099, 16'h0007, 1'b0, 9'h099);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule